// File: doc/BRIEF.md
# Quad-word byte-lane link transmitter

This block sends 16-byte quad-words to a receiving processor over an 8-bit data lane with a forwarded strobe clock. It runs entirely in the local parallel clock (PCLK) domain. Quad-words come in from an upstream packer through a valid/ready handshake, and the block serialises each one onto the lane, one byte per PCLK cycle. The strobe line changes level with every byte, so each level of the strobe carries one byte.

The receiver controls the flow through one ready line. Before the first transfer the block needs a settled ready level for a fixed number of cycles. While a quad-word is on the lane, a low-then-high pulse on the ready line arms the next one. That next quad-word then starts in the cycle right after the last byte, with no startup wait. Without the pulse the block falls back to idle and waits again. A single configuration bit records whether PCLK comes from outside (the reset value) or from the local master clock. The bit is stored only and has no effect on the datapath.

Top module: `qword_link_tx`

## Requirements
- R1: While reset is held, `lnk_clk` is 0, `lnk_dat` is 0, `up_ready` is 0 and `pclk_src` is 0.
- R2: From idle, the first byte appears on the lane only after `lnk_rdy` has been sampled high at START_WAIT+1 consecutive rising edges (7 with the default of 6). The byte appears in the cycle after the last of those edges. A low sample restarts the count.
- R3: Byte k of a quad-word (k = 0 first) is `up_data[8k+7:8k]`, so the least significant byte goes out first and every accepted word is sent whole, in acceptance order.
- R4: During a transfer exactly one byte is on the lane per PCLK cycle and `lnk_clk` changes level every cycle. It is 1 with even-numbered bytes and 0 with odd-numbered bytes. Outside a transfer it rests at 0.
- R5: `up_ready` is 0 while bytes 0 to 14 of a quad-word are on the lane. A word is accepted only at a quad-word boundary.
- R6: The next word is armed when `lnk_rdy` is sampled low at an edge that ends one of bytes 0 to 14, and then sampled high at a later edge up to the one ending byte 15. If the next word is valid, its byte 0 follows byte 15 in the very next cycle.
- R7: If no pulse arrives and `lnk_rdy` stays high, the lane goes quiet (`lnk_clk` 0, `lnk_dat` 0). The next byte 0 appears 8 cycles after the last byte, which means a full new startup wait.
- R8: If `lnk_rdy` goes low during a transfer and stays low, no further byte is sent while it stays low.
- R9: If the next word is armed but no word is valid at byte 15, the lane goes quiet and `up_ready` stays 1. Byte 0 of the next word appears in the cycle after it is accepted, with no startup wait.
- R10: `pclk_src` takes `cfg_int_clk` on a cycle with `cfg_we` high and holds its value otherwise. 0 means external PCLK and 1 means derived from the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCLK, the single clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the PCLK source bit |
| cfg_int_clk | input | 1 | Value written to the PCLK source bit |
| pclk_src | output | 1 | Stored PCLK source bit (0 external, 1 internal) |
| up_valid | input | 1 | Upstream quad-word valid |
| up_data | input | 128 | Upstream quad-word, byte k in bits 8k+7:8k |
| up_ready | output | 1 | Block accepts `up_data` at this edge when `up_valid` is high |
| lnk_rdy | input | 1 | Receiver ready / acknowledge line |
| lnk_clk | output | 1 | Forwarded strobe clock |
| lnk_dat | output | 8 | Lane data byte |

## Verification
A word accepted at one edge shows its byte 0 in the following cycle. From idle, that is START_WAIT+1 cycles after `lnk_rdy` is raised. After an armed word it is exactly 16 cycles after the previous byte 0, and without an arm pulse it is 23 cycles after. The bench samples the outputs at falling edges and drives inputs just after them. It logs the cycle of every byte 0 and compares it with these counts, and it sweeps every low and high pulse position inside a word. Byte values and strobe phase are checked on every strobe change against a word pattern computed from the word's index.

// File: rtl/qlt_pkg.sv
// Shared types for the quad-word link transmitter.
package qlt_pkg;

    // Top-level transfer state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for a settled ready line
        ST_SEND  = 2'd1,  // a quad-word is on the lane
        ST_ARMED = 2'd2   // receiver armed, no upstream word yet
    } link_state_e;

endpackage

// File: rtl/qlt_start_wait.sv
// Startup delay counter.
// Counts consecutive cycles with the ready line high while enabled, and
// saturates at WAIT_CYC. Any low sample or a dropped enable clears it.
// Assumes the caller gates the final start decision with the live ready level.
module qlt_start_wait #(
    parameter int unsigned WAIT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rdy,
    output logic done
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt;

    // Count sampled-high ready cycles while idle, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en && rdy) begin
            if (cnt != CW'(WAIT_CYC)) begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign done = (cnt == CW'(WAIT_CYC));

    AST_WAIT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rdy)); // R2

endmodule

// File: rtl/qlt_ack_det.sv
// Arm-pulse detector.
// Looks for a low sample followed by a high sample on the ready line while a
// quad-word is being sent. The arm output also covers a return to high
// in the current cycle, so a pulse that ends on the last byte still counts.
// Both flags are cleared when a new word is loaded.
module qlt_ack_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic rdy,
    output logic arm
);
    logic low_q;
    logic armed_q;

    // Remember a low sample seen during the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b0;
        end else if (clr) begin
            low_q <= 1'b0;
        end else if (active && !rdy) begin
            low_q <= 1'b1;
        end
    end

    // Latch the return to high that follows the low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr) begin
            armed_q <= 1'b0;
        end else if (active && low_q && rdy) begin
            armed_q <= 1'b1;
        end
    end

    assign arm = armed_q || (low_q && rdy);

    AST_ARM_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> low_q); // R6

endmodule

// File: rtl/qlt_serializer.sv
// Byte serializer with forwarded strobe.
// Loads a whole quad-word and shifts it out least significant byte first,
// one byte per cycle. The strobe starts high on byte 0 and changes level
// on every byte. Assumes an even byte count, so the strobe ends each word
// low. The lane reads zero when idle.
module qlt_serializer #(
    parameter int unsigned BYTES  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [BYTES*BYTE_W-1:0] load_data,
    output logic [BYTE_W-1:0]       dat,
    output logic                    lclk,
    output logic                    busy,
    output logic                    last
);
    localparam int unsigned WW   = BYTES * BYTE_W;
    localparam int unsigned IW   = $clog2(BYTES);
    localparam int unsigned LAST = BYTES - 1;

    logic [WW-1:0] shreg;
    logic [IW-1:0] idx;

    // Load, shift and stop the byte stream; strobe follows each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            busy  <= 1'b0;
            lclk  <= 1'b0;
        end else if (load) begin
            shreg <= load_data;
            idx   <= '0;
            busy  <= 1'b1;
            lclk  <= 1'b1;
        end else if (busy && (idx != IW'(LAST))) begin
            shreg <= shreg >> BYTE_W;
            idx   <= idx + 1'b1;
            lclk  <= ~lclk;
        end else if (busy) begin
            shreg <= '0;
            idx   <= '0;
            busy  <= 1'b0;
            lclk  <= 1'b0;
        end
    end

    assign dat  = shreg[BYTE_W-1:0];
    assign last = busy && (idx == IW'(LAST));

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && idx == $past(idx) + 1'b1)); // R4
    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || lclk != $past(lclk))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!lclk && dat == '0)); // R7

endmodule

// File: rtl/qword_link_tx.sv
// Quad-word byte-lane link transmitter (top).
// Accepts quad-words from an upstream valid/ready source and sends them on
// an 8-bit lane with a forwarded strobe. A startup wait runs before the first
// word. A receiver low-high pulse during a word chains the next word with
// no gap. Also holds the PCLK source configuration bit.
// Assumes a single clock domain and an even byte count per word.
module qword_link_tx #(
    parameter int unsigned QW_BYTES   = 16,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned START_WAIT = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_int_clk,
    output logic                       pclk_src,
    input  logic                       up_valid,
    input  logic [QW_BYTES*BYTE_W-1:0] up_data,
    output logic                       up_ready,
    input  logic                       lnk_rdy,
    output logic                       lnk_clk,
    output logic [BYTE_W-1:0]          lnk_dat
);
    import qlt_pkg::*;

    link_state_e state_q;
    link_state_e state_d;
    logic        hs;
    logic        wait_done;
    logic        arm;
    logic        busy;
    logic        last;

    assign hs = up_valid && up_ready;

    qlt_start_wait #(
        .WAIT_CYC (START_WAIT)
    ) i_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_IDLE),
        .rdy   (lnk_rdy),
        .done  (wait_done)
    );

    qlt_ack_det i_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hs),
        .active (busy),
        .rdy    (lnk_rdy),
        .arm    (arm)
    );

    qlt_serializer #(
        .BYTES  (QW_BYTES),
        .BYTE_W (BYTE_W)
    ) i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hs),
        .load_data (up_data),
        .dat       (lnk_dat),
        .lclk      (lnk_clk),
        .busy      (busy),
        .last      (last)
    );

    // Offer acceptance only at a quad-word boundary.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  up_ready = wait_done && lnk_rdy;
            ST_SEND:  up_ready = last && arm;
            ST_ARMED: up_ready = 1'b1;
            default:  up_ready = 1'b0;
        endcase
    end

    // Choose the next transfer state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hs) state_d = ST_SEND;
            ST_SEND: begin
                if (last) begin
                    if (hs)       state_d = ST_SEND;
                    else if (arm) state_d = ST_ARMED;
                    else          state_d = ST_IDLE;
                end
            end
            ST_ARMED: if (hs) state_d = ST_SEND;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Transfer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // PCLK source bit, external after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      pclk_src <= 1'b0;
        else if (cfg_we) pclk_src <= cfg_int_clk;
    end

    AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && up_ready) |-> last); // R5
    AST_ARMED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && up_valid) |=> busy); // R9
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(pclk_src)); // R10

endmodule

// File: tb/test_qword_link_tx.sv
module test_qword_link_tx;
    localparam int NB    = 16;
    localparam int BW    = 8;
    localparam int WAITC = 6;
    localparam int QW    = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_int_clk = 1'b0;
    logic          up_valid = 1'b0;
    logic          lnk_rdy = 1'b0;
    logic          pclk_src;
    logic          up_ready;
    logic          lnk_clk;
    logic [BW-1:0] lnk_dat;
    logic [QW-1:0] up_data;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   wr_idx = 0;
    int   sidx = 0;
    int   nfirst = 0;
    int   last_first = -1;
    logic prev_clk = 1'b0;
    logic hs_pend = 1'b0;
    logic mon_en = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [BW-1:0] exp_byte(int w, int k);
        return BW'((w * NB + k) * 13 + w + 5);
    endfunction

    function automatic logic [QW-1:0] mkword(int w);
        logic [QW-1:0] r;
        for (int k = 0; k < NB; k++) r[k*BW +: BW] = exp_byte(w, k);
        return r;
    endfunction

    assign up_data = mkword(wr_idx);

    qword_link_tx i_qword_link_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_int_clk (cfg_int_clk),
        .pclk_src    (pclk_src),
        .up_valid    (up_valid),
        .up_data     (up_data),
        .up_ready    (up_ready),
        .lnk_rdy     (lnk_rdy),
        .lnk_clk     (lnk_clk),
        .lnk_dat     (lnk_dat)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lane monitor: samples at falling edges, a strobe change marks a byte.
    always @(negedge clk) begin
        cyc++;
        if (hs_pend) wr_idx++;
        if (mon_en) begin
            if (lnk_clk != prev_clk) begin
                check(lnk_dat == exp_byte(sidx / NB, sidx % NB), "R3 byte value",
                      int'(lnk_dat), int'(exp_byte(sidx / NB, sidx % NB)));
                check(lnk_clk == ((sidx % 2) == 0), "R4 strobe phase",
                      int'(lnk_clk), int'((sidx % 2) == 0));
                if ((sidx % NB) != NB - 1)
                    check(!up_ready, "R5 ready mid-word", int'(up_ready), 0);
                if ((sidx % NB) == 0) begin
                    nfirst++;
                    last_first = cyc;
                end
                sidx++;
            end else begin
                check(lnk_dat == '0 && lnk_clk == 1'b0, "R7 quiet lane",
                      int'({lnk_clk, lnk_dat}), 0);
            end
        end
        prev_clk = lnk_clk;
        #2 hs_pend = up_valid && up_ready;
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_start(input int prev_n, input int exp_cyc, input string req);
        int guard = 0;
        while (nfirst == prev_n && guard < 80) begin
            tick(1);
            guard++;
        end
        check(last_first == exp_cyc, req, last_first, exp_cyc);
    endtask

    // Called in the byte-0 cycle; returns 16 cycles later.
    task automatic run_word(input int d, input int r, input logic drop_v);
        for (int k = 0; k < NB; k++) begin
            if (k == d) lnk_rdy = 1'b0;
            if (k == r) lnk_rdy = 1'b1;
            if (drop_v && k == NB - 2) up_valid = 1'b0;
            if (k < NB - 1) tick(1);
        end
        tick(1);
    endtask

    initial begin
        int c0;
        int f;
        int n;
        tick(3);
        check(lnk_clk == 1'b0, "R1 strobe in reset", int'(lnk_clk), 0);
        check(lnk_dat == '0, "R1 lane in reset", int'(lnk_dat), 0);
        check(up_ready == 1'b0, "R1 ready in reset", int'(up_ready), 0);
        check(pclk_src == 1'b0, "R1 source bit in reset", int'(pclk_src), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        tick(1);

        // R10 source bit write and hold
        cfg_we = 1'b1; cfg_int_clk = 1'b1;
        tick(1);
        check(pclk_src == 1'b1, "R10 write 1", int'(pclk_src), 1);
        cfg_we = 1'b0; cfg_int_clk = 1'b0;
        tick(2);
        check(pclk_src == 1'b1, "R10 hold", int'(pclk_src), 1);
        cfg_we = 1'b1;
        tick(1);
        check(pclk_src == 1'b0, "R10 write 0", int'(pclk_src), 0);
        cfg_we = 1'b0;

        // R2 startup wait, interrupted once
        up_valid = 1'b1;
        lnk_rdy = 1'b1;
        tick(4);
        lnk_rdy = 1'b0;
        tick(1);
        check(nfirst == 0, "R2 no early start", nfirst, 0);
        lnk_rdy = 1'b1;
        c0 = cyc;
        wait_start(0, c0 + WAITC + 1, "R2 first byte after wait");

        // R7 no pulse, ready held high
        f = last_first;
        n = nfirst;
        run_word(-1, -1, 1'b0);
        wait_start(n, f + NB + WAITC + 1, "R7 fresh wait after unarmed word");

        // R6 sweep of every low/high pulse position
        for (int d = 0; d < NB - 1; d++) begin
            for (int r = d + 1; r < NB; r++) begin
                f = last_first;
                n = nfirst;
                run_word(d, r, 1'b0);
                check(nfirst == n + 1 && last_first == f + NB, "R6 gapless chain",
                      last_first, f + NB);
            end
        end

        // R8 ready dropped and left low
        n = nfirst;
        run_word(5, -1, 1'b0);
        check(nfirst == n, "R8 stop at word end", nfirst, n);
        tick(10);
        check(nfirst == n, "R8 no send while low", nfirst, n);
        lnk_rdy = 1'b1;
        c0 = cyc;
        wait_start(n, c0 + WAITC + 1, "R2 restart after low");

        // R9 armed with no upstream word
        n = nfirst;
        run_word(2, 4, 1'b1);
        check(nfirst == n, "R9 no word sent", nfirst, n);
        check(up_ready == 1'b1, "R9 ready while armed", int'(up_ready), 1);
        tick(4);
        check(nfirst == n, "R9 still waiting", nfirst, n);
        up_valid = 1'b1;
        c0 = cyc;
        wait_start(n, c0 + 1, "R9 start next cycle");

        // final word, then drain
        run_word(-1, -1, 1'b1);
        tick(10);
        check(sidx == nfirst * NB, "R3 whole words sent", sidx, nfirst * NB);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule